// File: doc/BRIEF.md
# Glitch-Free Clock Divider Bank

This block turns one fast clock into six divided clock outputs and one fixed feedback tap. The fast clock runs at eight times a reference frequency. A two-bit ratio code picks the common divide ratio of the six outputs. A power-save level doubles that ratio. A two-bit shutdown code parks chosen groups of outputs low while the rest keep toggling. The feedback tap divides by eight at all times, so a loop closed through it stays locked whatever the other controls do.

All three controls pass through a two-flop synchronizer. A new setting is adopted only at the edge that starts a frame, and a frame is one period of the slowest possible output. Every allowed ratio divides the frame length exactly, so each output has just finished a whole period when a change lands. Because of this, no output can show a short high or low phase. A one-cycle flag reports each frame in which a new setting took hold.

Top module: `clkdiv_bank`

## Requirements
- R1: `fb_clk` has a period of 8 fast-clock cycles, high for the first 4 and low for the last 4. No ratio, power-save or shutdown setting changes it.
- R2: Ratio code 00 divides the fast clock by 2, code 01 by 4, and codes 10 and 11 both by 12. Each output is high for the first half of its period and low for the second half.
- R3: While power-save is applied, every output period is twice the period that R2 gives.
- R4: Shutdown code 00 enables all outputs. Code 01 holds outputs 4 and 5 low. Code 10 holds outputs 2 to 5 low. Code 11 holds all six low. A held output reads 0.
- R5: A frame is 24 fast-clock cycles, counted from the first edge after reset. A control value that has been stable for at least three edges before a frame's first edge governs that whole frame. A control value that comes and goes inside a frame has no effect.
- R6: An output that is shut off stops only after a complete low phase. An output that is re-enabled starts with a full high phase.
- R7: All enabled outputs carry the same level on every cycle, and each rises on the first cycle of a frame.
- R8: `mode_applied` is high for exactly the first cycle of a frame whose setting differs from the previous frame's setting. It is low otherwise.
- R9: During reset all clock outputs and `mode_applied` are low. The first frame after reset uses ratio code 00, no power-save and shutdown code 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast clock, eight times the reference |
| rst_n | input | 1 | Active-low asynchronous reset |
| ratio_sel | input | 2 | Divide-ratio code |
| pwr_save | input | 1 | High to halve every output frequency |
| shut_code | input | 2 | Output group shutdown code |
| clk_out | output | 6 | Divided clock outputs |
| fb_clk | output | 1 | Fixed divide-by-8 feedback tap |
| mode_applied | output | 1 | One-cycle pulse when a new setting takes effect |

## Verification
The bench sweeps every combination of ratio code, power-save and shutdown code, holding each for two frames. It predicts every output level on every cycle from the frame phase. Controls always change in mid-frame, so a design that switched at once would cut a period short, and one that ignored the frame boundary would show a phase shift; both show up as level mismatches in the cycles right after the change. The sweep ends with a short power-save pulse that lies entirely inside a frame; a design that latched it would halve the outputs or raise the flag. The check of the flag on every first cycle exposes a design that pulses it on every frame or that misses real changes.

// File: rtl/cdb_pkg.sv
package cdb_pkg;

    typedef struct packed {
        logic [1:0] ratio;
        logic       psave;
        logic [1:0] shut;
    } cdb_cfg_t;

    localparam int unsigned CFG_W = $bits(cdb_cfg_t);

    // Effective divide ratio of the six outputs.
    function automatic int unsigned eff_ratio(cdb_cfg_t c);
        int unsigned base;
        case (c.ratio)
            2'b00:   base = 2;
            2'b01:   base = 4;
            default: base = 12;
        endcase
        return c.psave ? 2 * base : base;
    endfunction

    // Number of low-index outputs left running for a shutdown code.
    function automatic int unsigned keep_count(logic [1:0] shut, int unsigned n_out);
        case (shut)
            2'b00:   return n_out;
            2'b01:   return n_out - 2;
            2'b10:   return 2;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/cdb_sync.sv
module cdb_sync #(
    parameter int unsigned W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] s1_d, s1_q, s2_d, s2_q;

    always_comb begin
        s1_d = din;
        s2_d = s1_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
        end
    end

    assign dout = s2_q;
endmodule

// File: rtl/cdb_phase.sv
module cdb_phase
    import cdb_pkg::*;
#(
    parameter int unsigned NUM_OUT = 6,
    parameter int unsigned CNT_W   = 5,
    parameter int unsigned FB_DIV  = 8
) (
    input  logic [CNT_W-1:0]   cnt,
    input  cdb_cfg_t           cfg,
    output logic [NUM_OUT-1:0] lvl,
    output logic               fb_lvl
);
    int unsigned n_div;
    int unsigned keep;
    logic        hi;

    always_comb begin
        n_div  = eff_ratio(cfg);
        keep   = keep_count(cfg.shut, NUM_OUT);
        hi     = (32'(cnt) % n_div) < (n_div / 2);
        fb_lvl = (32'(cnt) % FB_DIV) < (FB_DIV / 2);
    end

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
        assign lvl[i] = hi && (i < keep);
    end
endmodule

// File: rtl/clkdiv_bank.sv
module clkdiv_bank
    import cdb_pkg::*;
#(
    parameter int unsigned NUM_OUT = 6,
    parameter int unsigned FB_DIV  = 8,
    // Must be a multiple of every effective ratio and of FB_DIV.
    parameter int unsigned FRAME   = 24
) (
    input  logic               clk_fast,
    input  logic               rst_n,
    input  logic [1:0]         ratio_sel,
    input  logic               pwr_save,
    input  logic [1:0]         shut_code,
    output logic [NUM_OUT-1:0] clk_out,
    output logic               fb_clk,
    output logic               mode_applied
);
    localparam int unsigned CNT_W = $clog2(FRAME);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME - 1);

    typedef struct packed {
        logic [CNT_W-1:0]   cnt;
        cdb_cfg_t           cfg;
        logic [NUM_OUT-1:0] outs;
        logic               fb;
        logic               applied;
    } bank_st_t;

    bank_st_t st_d, st_q;

    cdb_cfg_t           raw_cfg, sync_cfg, cfg_nxt;
    logic [CNT_W-1:0]   cnt_nxt;
    logic [NUM_OUT-1:0] lvl_nxt;
    logic               fb_nxt;
    logic               frame_end;

    assign raw_cfg = '{ratio: ratio_sel, psave: pwr_save, shut: shut_code};

    cdb_sync #(.W(CFG_W)) u_sync (
        .clk   (clk_fast),
        .rst_n (rst_n),
        .din   (raw_cfg),
        .dout  (sync_cfg)
    );

    assign frame_end = (st_q.cnt == LAST);
    assign cnt_nxt   = frame_end ? '0 : st_q.cnt + 1'b1;
    assign cfg_nxt   = frame_end ? sync_cfg : st_q.cfg;

    cdb_phase #(.NUM_OUT(NUM_OUT), .CNT_W(CNT_W), .FB_DIV(FB_DIV)) u_phase (
        .cnt    (cnt_nxt),
        .cfg    (cfg_nxt),
        .lvl    (lvl_nxt),
        .fb_lvl (fb_nxt)
    );

    always_comb begin
        st_d         = st_q;
        st_d.cnt     = cnt_nxt;
        st_d.cfg     = cfg_nxt;
        st_d.outs    = lvl_nxt;
        st_d.fb      = fb_nxt;
        st_d.applied = frame_end && (sync_cfg != st_q.cfg);
    end

    always_ff @(posedge clk_fast or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.cnt     <= LAST;
        end else begin
            st_q <= st_d;
        end
    end

    logic [CNT_W-1:0] cnt_q;
    cdb_cfg_t         cfg_q;
    assign cnt_q        = st_q.cnt;
    assign cfg_q        = st_q.cfg;
    assign clk_out      = st_q.outs;
    assign fb_clk       = st_q.fb;
    assign mode_applied = st_q.applied;
endmodule

// File: rtl/cdb_checker.sv
module cdb_checker
    import cdb_pkg::*;
#(
    parameter int unsigned NUM_OUT = 6,
    parameter int unsigned CNT_W   = 5,
    parameter int unsigned FB_DIV  = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [CNT_W-1:0]   cnt,
    input cdb_cfg_t           cfg,
    input logic [NUM_OUT-1:0] outs,
    input logic               fb,
    input logic               applied
);
    logic [NUM_OUT-1:0] en_mask;
    always_comb begin
        for (int i = 0; i < NUM_OUT; i++)
            en_mask[i] = (i < keep_count(cfg.shut, NUM_OUT));
    end

    a_r4_off_low: assert property (@(posedge clk) disable iff (!rst_n)
        (outs & ~en_mask) == '0);

    a_r7_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (outs == '0) || (outs == en_mask));

    a_r5_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != '0) |-> $stable(cfg));

    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        applied |-> (cnt == '0));

    a_r8_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
        applied |=> !applied);

    a_r1_fb_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fb) |-> ((32'(cnt) % FB_DIV) == 0));

    a_r6_restart_high: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|outs) |-> ((32'(cnt) % eff_ratio(cfg)) == 0));
endmodule

bind clkdiv_bank cdb_checker #(
    .NUM_OUT (NUM_OUT),
    .CNT_W   (CNT_W),
    .FB_DIV  (FB_DIV)
) u_chk (
    .clk     (clk_fast),
    .rst_n   (rst_n),
    .cnt     (cnt_q),
    .cfg     (cfg_q),
    .outs    (clk_out),
    .fb      (fb_clk),
    .applied (mode_applied)
);

// File: tb/tb_clkdiv_bank.sv
module tb_clkdiv_bank;
    logic       clk_fast = 1'b0;
    logic       rst_n    = 1'b0;
    logic [1:0] ratio_sel = 2'b00;
    logic       pwr_save  = 1'b0;
    logic [1:0] shut_code = 2'b00;
    logic [5:0] clk_out;
    logic       fb_clk;
    logic       mode_applied;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #4 clk_fast = ~clk_fast;

    clkdiv_bank dut (
        .clk_fast     (clk_fast),
        .rst_n        (rst_n),
        .ratio_sel    (ratio_sel),
        .pwr_save     (pwr_save),
        .shut_code    (shut_code),
        .clk_out      (clk_out),
        .fb_clk       (fb_clk),
        .mode_applied (mode_applied)
    );

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h at %0t", req, got, exp, $time);
        end
    endtask

    // Expected six-output level from requirements R2, R3, R4, R7.
    function automatic logic [5:0] exp_outs(logic [4:0] c, int p);
        int n, keep;
        logic [5:0] v;
        n = (c[1:0] == 2'b00) ? 2 : (c[1:0] == 2'b01) ? 4 : 12;
        if (c[2]) n = 2 * n;
        case (c[4:3])
            2'b00: keep = 6;
            2'b01: keep = 4;
            2'b10: keep = 2;
            default: keep = 0;
        endcase
        for (int i = 0; i < 6; i++)
            v[i] = (i < keep) && ((p % n) < (n / 2));
        return v;
    endfunction

    initial begin
        logic [4:0] cur, prev, nxt;
        cur  = '0;
        prev = '0;
        repeat (3) @(negedge clk_fast);
        check("R9 reset outputs", {24'd0, clk_out, fb_clk, mode_applied}, 32'd0);
        rst_n = 1'b1;
        for (int f = 0; f < 67; f++) begin
            nxt = (f < 64) ? 5'(f / 2) : 5'd0;
            for (int p = 0; p < 24; p++) begin
                @(negedge clk_fast);
                check("R2 R3 R4 R6 R7 outputs", {26'd0, clk_out}, {26'd0, exp_outs(cur, p)});
                check("R1 feedback", {31'd0, fb_clk}, {31'd0, ((p % 8) < 4)});
                check("R8 applied flag", {31'd0, mode_applied},
                      {31'd0, (p == 0) && (cur != prev)});
                if (p == 10) begin
                    ratio_sel = nxt[1:0];
                    pwr_save  = nxt[2];
                    shut_code = nxt[4:3];
                end
                // R5: a power-save blip inside the frame must not be taken
                if (f >= 64 && p == 4)  pwr_save = 1'b1;
                if (f >= 64 && p == 8)  pwr_save = 1'b0;
            end
            prev = cur;
            cur  = nxt;
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got hang expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end
endmodule